// File: doc/BRIEF.md
# Firmware Root-Pointer Scanner

This block finds the root pointer structure of the platform's firmware configuration tables. It has no memory of its own. A start pulse makes it fetch a 16-bit real-mode segment value from a fixed location and multiply that value by 16. If the result is non-zero, it checks a short region at that address first. It then walks a fixed firmware window in low memory.

At each 16-byte-aligned candidate it compares the bytes against an 8-byte signature and leaves the candidate at the first byte that differs. After a full signature match it keeps reading the rest of the 20-byte structure and keeps a running modulo-256 sum of the bytes. It also captures the revision byte, which tells the version-1 table layout from the version-2 layout.

All reads go through a simple request/valid byte port, one byte per handshake. Memory latency can be any number of cycles. The result is a one-cycle completion pulse. The found flag, the structure address and the revision are held until the next start.

Top module: `fwtab_scan`

## Requirements
- R1: After an accepted start, the first read is at `PTR_ADDR` and gives the low byte of the segment value. The second read is at `PTR_ADDR+1` and gives the high byte.
- R2: If the segment value is non-zero, candidates at segment*16 + 16k for k = 0 .. ALT_LEN/16-1 are tested, in rising order, before any window candidate. If the segment value is zero, that region is skipped.
- R3: Window candidates are the 16-byte-aligned addresses from `WIN_LO` up to the highest aligned address whose 20 bytes lie inside the window. No read in the window phase goes outside that span. An unaligned structure is never reported.
- R4: A candidate matches only when its bytes 0..7 equal 52 53 44 20 50 54 52 20 (hex) in that order. This is the 64-bit constant 0x2052545020445352 stored little-endian.
- R5: A matching candidate is accepted only if its bytes 0..19 add up to 0 modulo 256. A match with a bad sum does not stop the scan, which goes on to the next candidate.
- R6: On success, `revision` holds byte 15 of the accepted structure and `match_addr` holds its first address.
- R7: If no candidate is accepted, the scan ends with `found`=0, `match_addr`=0 and `revision`=0.
- R8: `done` is high for exactly one cycle per scan. `found`, `match_addr` and `revision` stay constant until the next accepted start. An accepted start clears them on the following cycle.
- R9: A start pulse that arrives while a scan is running is ignored. That scan still ends once, with its own result.
- R10: `mem_req` and `mem_addr` stay constant while a request is waiting for `mem_valid`. Each `mem_valid` cycle consumes exactly one byte.
- R11: When more than one candidate would be accepted, the first one in scan order is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a scan when the block is idle |
| mem_req | output | 1 | Byte read request, held until served |
| mem_addr | output | ADDR_W | Byte address of the pending read |
| mem_valid | input | 1 | Read data present this cycle |
| mem_data | input | 8 | Read data byte |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A valid structure was found |
| match_addr | output | ADDR_W | Address of the accepted structure, zero if none |
| revision | output | 8 | Revision byte of the accepted structure, zero if none |

## Verification
The embedded properties check on every cycle that `done` is a single-cycle pulse, that the request is withdrawn when it fires, that the address does not change while a read waits, that the segment pointer is the first thing read, that window-phase reads stay inside the allowed span, and that the results do not change between scans. Only the bench scenarios can show which address is reported, and in which order the pointer region and the window are visited. The same holds for rejecting a partial signature, a byte-reversed signature or a bad sum, and for the revision value. The bench covers these by sweeping a valid structure over every aligned window slot of a 4 KiB configuration, with and without random memory stalls.

// File: rtl/fwtab_scan_pkg.sv
package fwtab_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PTR_LO,
        ST_PTR_HI,
        ST_SCAN
    } scan_st_e;

    localparam int unsigned SIG_BYTES  = 8;
    localparam int unsigned BODY_BYTES = 20;
    localparam int unsigned REV_OFFSET = 15;
    localparam int unsigned STRIDE     = 16;
    localparam int unsigned IDX_W      = 5;

endpackage

// File: rtl/fwtab_sig_byte.sv
// Selects the expected signature byte for a byte index within a candidate.
module fwtab_sig_byte
    import fwtab_scan_pkg::*;
#(
    parameter logic [63:0] SIG = 64'h2052_5450_2044_5352
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       exp_byte,
    output logic             in_sig
);

    always_comb begin
        exp_byte = 8'h00;
        for (int i = 0; i < int'(SIG_BYTES); i++) begin
            if (idx == IDX_W'(i)) begin
                exp_byte = SIG[8*i +: 8];
            end
        end
        in_sig = (idx < IDX_W'(SIG_BYTES));
    end

endmodule

// File: rtl/fwtab_cand_step.sv
// Works out the candidate after the current one and flags the end of the window.
module fwtab_cand_step
    import fwtab_scan_pkg::*;
#(
    parameter int unsigned         ADDR_W    = 20,
    parameter logic [ADDR_W-1:0]   WIN_FIRST = '0,
    parameter logic [ADDR_W-1:0]   WIN_LAST  = '0
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              in_alt,
    input  logic [ADDR_W-1:0] alt_last,
    output logic [ADDR_W-1:0] nxt_base,
    output logic              nxt_alt,
    output logic              exhausted
);

    always_comb begin
        nxt_base  = base + ADDR_W'(STRIDE);
        nxt_alt   = in_alt;
        exhausted = 1'b0;
        if (in_alt && (base == alt_last)) begin
            nxt_base = WIN_FIRST;
            nxt_alt  = 1'b0;
        end else if (!in_alt && (base == WIN_LAST)) begin
            exhausted = 1'b1;
        end
    end

endmodule

// File: rtl/fwtab_scan.sv
module fwtab_scan
    import fwtab_scan_pkg::*;
#(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned WIN_LO   = 32'h000E_0000,
    parameter int unsigned WIN_HI   = 32'h000F_FFFF,
    parameter int unsigned PTR_ADDR = 32'h0000_040E,
    parameter int unsigned ALT_LEN  = 1024,
    parameter logic [63:0] SIG      = 64'h2052_5450_2044_5352
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [7:0]        mem_data,
    output logic              done,
    output logic              found,
    output logic [ADDR_W-1:0] match_addr,
    output logic [7:0]        revision
);

    localparam logic [ADDR_W-1:0] WIN_FIRST = ADDR_W'((WIN_LO + STRIDE - 1) / STRIDE * STRIDE);
    localparam logic [ADDR_W-1:0] WIN_LAST  = ADDR_W'((WIN_HI + 1 - BODY_BYTES) / STRIDE * STRIDE);
    localparam logic [ADDR_W-1:0] WIN_TOP   = WIN_LAST + ADDR_W'(BODY_BYTES - 1);
    localparam logic [ADDR_W-1:0] PTR_LO_A  = ADDR_W'(PTR_ADDR);
    localparam logic [ADDR_W-1:0] PTR_HI_A  = ADDR_W'(PTR_ADDR + 1);
    localparam logic [ADDR_W-1:0] ALT_SPAN  = ADDR_W'(ALT_LEN - STRIDE);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(BODY_BYTES - 1);
    localparam logic [IDX_W-1:0]  REV_IDX   = IDX_W'(REV_OFFSET);

    typedef struct packed {
        scan_st_e          st;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] alt_last;
        logic              in_alt;
        logic [IDX_W-1:0]  idx;
        logic [7:0]        sum;
        logic [7:0]        rev_tmp;
        logic [7:0]        ptr_lo;
        logic              done;
        logic              found;
        logic [ADDR_W-1:0] hit_addr;
        logic [7:0]        hit_rev;
    } regs_t;

    regs_t q, d;

    logic [7:0]        exp_byte;
    logic              in_sig;
    logic [ADDR_W-1:0] nxt_base;
    logic              nxt_alt;
    logic              exhausted;
    logic [19:0]       seg_shift;
    logic [ADDR_W-1:0] seg_base;
    logic [7:0]        sum_nx;
    logic              advance;
    logic              accept;

    fwtab_sig_byte #(.SIG(SIG)) u_sig (
        .idx      (q.idx),
        .exp_byte (exp_byte),
        .in_sig   (in_sig)
    );

    fwtab_cand_step #(
        .ADDR_W    (ADDR_W),
        .WIN_FIRST (WIN_FIRST),
        .WIN_LAST  (WIN_LAST)
    ) u_step (
        .base      (q.base),
        .in_alt    (q.in_alt),
        .alt_last  (q.alt_last),
        .nxt_base  (nxt_base),
        .nxt_alt   (nxt_alt),
        .exhausted (exhausted)
    );

    assign seg_shift = {mem_data, q.ptr_lo, 4'h0};
    assign seg_base  = ADDR_W'(seg_shift);

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        sum_nx  = q.sum + mem_data;
        advance = 1'b0;
        accept  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st       = ST_PTR_LO;
                    d.found    = 1'b0;
                    d.hit_addr = '0;
                    d.hit_rev  = '0;
                end
            end
            ST_PTR_LO: begin
                if (mem_valid) begin
                    d.ptr_lo = mem_data;
                    d.st     = ST_PTR_HI;
                end
            end
            ST_PTR_HI: begin
                if (mem_valid) begin
                    d.st  = ST_SCAN;
                    d.idx = '0;
                    d.sum = '0;
                    if ({mem_data, q.ptr_lo} != 16'h0000) begin
                        d.base     = seg_base;
                        d.alt_last = seg_base + ALT_SPAN;
                        d.in_alt   = 1'b1;
                    end else begin
                        d.base   = WIN_FIRST;
                        d.in_alt = 1'b0;
                    end
                end
            end
            ST_SCAN: begin
                if (mem_valid) begin
                    d.sum = sum_nx;
                    d.idx = q.idx + IDX_W'(1);
                    if (q.idx == REV_IDX) begin
                        d.rev_tmp = mem_data;
                    end
                    if (in_sig && (mem_data != exp_byte)) begin
                        advance = 1'b1;
                    end else if (q.idx == LAST_IDX) begin
                        if (sum_nx == 8'h00) begin
                            accept = 1'b1;
                        end else begin
                            advance = 1'b1;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (accept) begin
            d.st       = ST_IDLE;
            d.done     = 1'b1;
            d.found    = 1'b1;
            d.hit_addr = q.base;
            d.hit_rev  = q.rev_tmp;
        end else if (advance) begin
            d.idx = '0;
            d.sum = '0;
            if (exhausted) begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end else begin
                d.base   = nxt_base;
                d.in_alt = nxt_alt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.st)
            ST_PTR_LO: mem_addr = PTR_LO_A;
            ST_PTR_HI: mem_addr = PTR_HI_A;
            default:   mem_addr = q.base + ADDR_W'(q.idx);
        endcase
    end

    assign mem_req    = (q.st != ST_IDLE);
    assign done       = q.done;
    assign found      = q.found;
    assign match_addr = q.hit_addr;
    assign revision   = q.hit_rev;

    // R1: the segment pointer is the first location fetched after an accepted start
    assert_ptr_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req) |=> (mem_req && (mem_addr == PTR_LO_A)));

    // R3: window-phase reads stay inside the span of the allowed candidates
    assert_window_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (q.st == ST_SCAN) && !q.in_alt) |->
        ((mem_addr >= WIN_FIRST) && (mem_addr <= WIN_TOP)));

    // R8: completion is a single-cycle pulse and the request is already withdrawn
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_idle_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R8: results hold between scans
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(start)) |->
        ($stable(found) && $stable(match_addr) && $stable(revision)));

    // R10: a pending read keeps its address until it is served
    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: tb/sim_fwtab_scan.sv
`timescale 1ns/1ps
module sim_fwtab_scan;

    localparam int AW      = 12;
    localparam int P_WLO   = 'h800;
    localparam int P_WHI   = 'hFFF;
    localparam int P_PTR   = 'h00E;
    localparam int P_ALT   = 64;
    localparam int W_LAST  = 'hFE0;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          vld;
    logic [7:0]    rdata;
    logic          done;
    logic          found;
    logic [AW-1:0] match_addr;
    logic [7:0]    revision;

    always #2.5 clk = ~clk;

    fwtab_scan #(
        .ADDR_W   (AW),
        .WIN_LO   (P_WLO),
        .WIN_HI   (P_WHI),
        .PTR_ADDR (P_PTR),
        .ALT_LEN  (P_ALT)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_valid  (vld),
        .mem_data   (rdata),
        .done       (done),
        .found      (found),
        .match_addr (match_addr),
        .revision   (revision)
    );

    logic [7:0]    mem [0:4095];
    logic          stall_en;
    logic          clr_log;
    int            alt_lo;
    bit            alt_on;

    logic [7:0]    lfsr;
    logic          pend;
    logic [AW-1:0] pend_a;
    logic [AW-1:0] first_a;
    logic [AW-1:0] second_a;
    int            n_reads;
    int            oob;
    int            hold_err;
    int            done_cnt;

    int checks   = 0;
    int failures = 0;

    function automatic bit addr_ok(input int a);
        if (a == P_PTR || a == P_PTR + 1) return 1'b1;
        if (alt_on && a >= alt_lo && a < alt_lo + P_ALT + 4) return 1'b1;
        if (a >= P_WLO && a <= W_LAST + 19) return 1'b1;
        return 1'b0;
    endfunction

    // Memory model: serves one request per handshake, with optional random stalls
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld      <= 1'b0;
            rdata    <= 8'h00;
            lfsr     <= 8'h5A;
            pend     <= 1'b0;
            pend_a   <= '0;
            first_a  <= '0;
            second_a <= '0;
            n_reads  <= 0;
            oob      <= 0;
            hold_err <= 0;
            done_cnt <= 0;
        end else begin
            lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (vld) begin
                vld  <= 1'b0;
                pend <= 1'b0;
            end else if (mem_req) begin
                if (pend && mem_addr != pend_a) hold_err <= hold_err + 1;
                pend   <= 1'b1;
                pend_a <= mem_addr;
                if (!(stall_en && lfsr[0])) begin
                    vld   <= 1'b1;
                    rdata <= mem[mem_addr];
                    if (n_reads == 0) first_a <= mem_addr;
                    if (n_reads == 1) second_a <= mem_addr;
                    n_reads <= n_reads + 1;
                    if (!addr_ok(int'(mem_addr))) oob <= oob + 1;
                end
            end
            if (done) done_cnt <= done_cnt + 1;
            if (clr_log) begin
                n_reads  <= 0;
                oob      <= 0;
                hold_err <= 0;
                done_cnt <= 0;
            end
        end
    end

    task automatic chk_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        alt_on = 1'b0;
        alt_lo = 0;
    endtask

    task automatic set_ptr(input int seg);
        mem[P_PTR]     = seg[7:0];
        mem[P_PTR + 1] = seg[15:8];
        alt_on = (seg != 0);
        alt_lo = (seg * 16) & 'hFFF;
    endtask

    // kind: 0 good, 1 bad sum, 2 byte 7 wrong, 3 signature byte-reversed
    task automatic place(input int a, input int rev, input int kind);
        logic [63:0] sig;
        logic [7:0]  b [0:19];
        int          s;
        sig = 64'h2052_5450_2044_5352;
        if (kind == 3) sig = 64'h5253_4420_5054_5220;
        for (int i = 0; i < 8; i++) b[i] = sig[8*i +: 8];
        if (kind == 2) b[7] = 8'h21;
        for (int i = 9; i < 15; i++) b[i] = 8'(8'h10 + i);
        b[15] = rev[7:0];
        for (int i = 16; i < 20; i++) b[i] = 8'(8'hA0 + i);
        b[8] = 8'h00;
        s = 0;
        for (int i = 0; i < 20; i++) s += b[i];
        b[8] = 8'(-s);
        if (kind == 1) b[8] = b[8] + 8'h01;
        for (int i = 0; i < 20; i++) mem[(a + i) & 'hFFF] = b[i];
    endtask

    logic          r_found;
    logic [AW-1:0] r_addr;
    logic [7:0]    r_rev;
    logic          r_done_after;

    task automatic run_scan(input bit mid_start);
        int cyc;
        clr_log = 1'b1;
        @(negedge clk);
        clr_log = 1'b0;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 30000) begin
            @(negedge clk);
            cyc++;
            if (mid_start && cyc == 20) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        end
        r_found = found;
        r_addr  = match_addr;
        r_rev   = revision;
        @(negedge clk);
        r_done_after = done;
        repeat (3) @(negedge clk);
        chk_eq("R8 done single cycle", int'(r_done_after), 0);
        chk_eq("R8 one done per scan", done_cnt, 1);
        chk_eq("R1 first read at pointer low", int'(first_a), P_PTR);
        chk_eq("R1 second read at pointer high", int'(second_a), P_PTR + 1);
        chk_eq("R3 reads within allowed spans", oob, 0);
        chk_eq("R10 address held while pending", hold_err, 0);
    endtask

    task automatic expect_res(input string tag, input bit f, input int a, input int rv);
        chk_eq({tag, " found"}, int'(r_found), int'(f));
        chk_eq({tag, " address"}, int'(r_addr), a);
        chk_eq({tag, " revision"}, int'(r_rev), rv);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        start    = 1'b0;
        stall_en = 1'b0;
        clr_log  = 1'b0;
        clear_mem();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R8 reset done", int'(done), 0);
        chk_eq("R8 reset found", int'(found), 0);
        chk_eq("R8 reset address", int'(match_addr), 0);
        chk_eq("R8 reset revision", int'(revision), 0);
        chk_eq("R10 reset request", int'(mem_req), 0);

        // R7: empty memory
        run_scan(1'b0);
        expect_res("R7 empty", 1'b0, 0, 0);

        // R3 R6: sweep a valid structure over every aligned window slot
        for (int k = 0; k <= (W_LAST - P_WLO) / 16; k++) begin
            clear_mem();
            stall_en = (k % 4 == 1);
            place(P_WLO + 16 * k, k + 1, 0);
            run_scan(1'b0);
            expect_res("R6 sweep", 1'b1, P_WLO + 16 * k, k + 1);
        end
        stall_en = 1'b0;

        // R3: slot past the last full candidate and an unaligned one
        clear_mem();
        place('hFF0, 8'h44, 0);
        run_scan(1'b0);
        expect_res("R3 beyond last slot", 1'b0, 0, 0);
        clear_mem();
        place('h808, 8'h44, 0);
        run_scan(1'b0);
        expect_res("R3 unaligned", 1'b0, 0, 0);

        // R4: partial and reversed signatures
        clear_mem();
        place('h900, 8'h02, 2);
        run_scan(1'b0);
        expect_res("R4 byte 7 wrong", 1'b0, 0, 0);
        clear_mem();
        place('h900, 8'h02, 3);
        run_scan(1'b0);
        expect_res("R4 reversed", 1'b0, 0, 0);

        // R5: bad sum skipped, later good one found
        clear_mem();
        place('h800, 8'h01, 1);
        place('h820, 8'h02, 0);
        stall_en = 1'b1;
        run_scan(1'b0);
        stall_en = 1'b0;
        expect_res("R5 bad sum skipped", 1'b1, 'h820, 8'h02);

        // R11: first in order wins
        clear_mem();
        place('h850, 8'h01, 0);
        place('h8A0, 8'h02, 0);
        run_scan(1'b0);
        expect_res("R11 lowest wins", 1'b1, 'h850, 8'h01);

        // R2: pointer region first, last pointer slot, then window
        clear_mem();
        set_ptr('h0010);
        place('h130, 8'h22, 0);
        place('h800, 8'h33, 0);
        run_scan(1'b0);
        expect_res("R2 pointer region first", 1'b1, 'h130, 8'h22);
        clear_mem();
        set_ptr('h0010);
        place('h140, 8'h22, 0);
        run_scan(1'b0);
        expect_res("R2 beyond pointer region", 1'b0, 0, 0);
        clear_mem();
        set_ptr('h0010);
        place('h9C0, 8'h55, 0);
        stall_en = 1'b1;
        run_scan(1'b0);
        stall_en = 1'b0;
        expect_res("R2 falls through to window", 1'b1, 'h9C0, 8'h55);

        // R9: start during a scan is ignored
        clear_mem();
        place('hC00, 8'h66, 0);
        run_scan(1'b1);
        expect_res("R9 busy start ignored", 1'b1, 'hC00, 8'h66);

        // R8: results hold when idle, then clear on the next start
        repeat (20) @(negedge clk);
        chk_eq("R8 found held", int'(found), 1);
        chk_eq("R8 address held", int'(match_addr), 'hC00);
        chk_eq("R8 revision held", int'(revision), 8'h66);
        clear_mem();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk_eq("R8 start clears found", int'(found), 0);
        chk_eq("R8 start clears address", int'(match_addr), 0);
        chk_eq("R8 start clears revision", int'(revision), 0);
        while (!done) @(negedge clk);
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule